// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns the addresses that bus-master devices issue for DMA into physical memory addresses. It takes one request at a time. While translation is off, the incoming address goes straight out as the physical address, one cycle after the request is accepted. While translation is on, the unit computes where the matching table entry sits in memory and issues a single 64-bit read for it. It then checks the entry's valid and write-permission bits and returns either the physical address or a fault code, marked by a one-cycle done pulse.

Two 64-bit registers set the behaviour. A control register holds the enable bit, the table-page-size bit and a 3-bit table-size code. A table base register holds the start address of the table. Software reaches each register as two 32-bit halves. The table-size code and the page-size bit together decide how many DMA address bits form the entry index. Each entry describes either a small (8 KiB) page or a large (64 KiB) page, and each page size has its own physical address mask.

Top module: `dma_xlate`

## Requirements
- R1: Register halves sit at byte offsets 0x0 (control bits 63:32), 0x4 (control bits 31:0), 0x8 (base bits 63:32) and 0xC (base bits 31:0). A write with reg_we_i stores reg_wdata_i into the selected half. reg_rdata_o shows the selected half combinationally. All halves reset to zero.
- R2: When control bit 0 is clear, an accepted request gives done_o in the following cycle with pa_o equal to the zero-extended req_addr_i and fault_o = 0, and no memory read is issued.
- R3: When control bit 0 is set and control bit 2 is clear, the entry read address is base + 8 × (req_addr_i[22+c:13]), where c is control bits 18:16 (0..7), truncated to PA_W bits.
- R4: When control bits 0 and 2 are set and c is 0..5, the entry read address is base + 8 × (req_addr_i[25+c:16]).
- R5: When control bits 0 and 2 are set and c is 6 or 7, no memory read is issued, and done_o follows in the next cycle with fault_o = 3 and pa_o = 0.
- R6: The entry is stored big-endian. mem_rdata_i bits 8k+7:8k carry the memory byte at mem_addr_o + k, and byte 0 is the most significant byte of the entry.
- R7: An entry with bit 63 clear gives fault_o = 1 and pa_o = 0, whatever the request direction.
- R8: A write request (req_write_i = 1) that hits a valid entry with bit 1 clear gives fault_o = 2 and pa_o = 0. A read request to the same entry succeeds.
- R9: A valid, permitted entry with bit 61 set gives pa_o = (entry & 0x1FFFFFF8000) | req_addr_i[15:0]. With bit 61 clear it gives pa_o = (entry & 0x1FFFFFFE000) | req_addr_i[12:0]. fault_o is 0 in both cases.
- R10: A translation keeps one memory read outstanding: mem_req_o is high for exactly one cycle, req_ready_o stays low until the result is produced, and done_o rises for one cycle in the cycle after the one in which mem_valid_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register half write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected register half |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Unit can accept a request |
| req_addr_i | input | DMA_AW | DMA address to translate |
| req_write_i | input | 1 | Request is a DMA write |
| done_o | output | 1 | Result valid pulse |
| pa_o | output | PA_W | Physical address result |
| fault_o | output | 2 | 0 ok, 1 invalid entry, 2 write protected, 3 bad table size |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | PA_W | Entry byte address |
| mem_valid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 64 | Entry read data, byte k in bits 8k+7:8k |

## Verification
The assertions take for granted that the memory side returns mem_valid_i exactly once per mem_req_o and never at any other time. They also assume the registers are not written while a translation is in flight, because the checks compare results with the request latched at acceptance. The bench respects both assumptions. Its memory model answers each read pulse once, after a fixed latency. The bench writes the registers only between requests, and it offers a new request only after the previous done pulse has been seen.

// File: rtl/dxl_pkg.sv
`timescale 1ns/1ps
package dxl_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_WPROT   = 2'd2,
    FLT_TSIZE   = 2'd3
  } dxl_fault_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PG64_BIT = 2;
  localparam int CTRL_TSZ_LSB  = 16;
  localparam int ENT_VALID_BIT = 63;
  localparam int ENT_BIG_BIT   = 61;
  localparam int ENT_WR_BIT    = 1;
  localparam int SMALL_SHIFT   = 13;
  localparam int LARGE_SHIFT   = 16;
  localparam int LARGE_PHYS_LSB = 15;
  localparam int IDX_MIN_BITS  = 10;
  localparam int NUM_TSZ       = 8;
  localparam int MAX_LARGE_TSZ = 5;
endpackage

// File: rtl/dxl_regs.sv
`timescale 1ns/1ps
module dxl_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [63:0] ctrl_o,
  output logic [63:0] base_o
);
  localparam int NHALVES = 4;

  logic [NHALVES-1:0][31:0] half_q;
  logic [1:0] sel;
  logic unused_lsb;

  assign sel = addr_i[3:2];
  assign unused_lsb = ^addr_i[1:0];

  // Slot order: ctrl hi, ctrl lo, base hi, base lo
  for (genvar h = 0; h < NHALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    half_q[h] <= '0;
      else if (we_i && sel == 2'(h))  half_q[h] <= wdata_i;
    end
  end

  assign rdata_o = half_q[sel];
  assign ctrl_o  = {half_q[0], half_q[1]};
  assign base_o  = {half_q[2], half_q[3]};
endmodule

// File: rtl/dxl_index.sv
`timescale 1ns/1ps
module dxl_index
  import dxl_pkg::*;
#(
  parameter int DMA_AW = 32,
  parameter int PA_W   = 41
) (
  input  logic [DMA_AW-1:0] dma_addr_i,
  input  logic [63:0]       base_i,
  input  logic              pg64_i,
  input  logic [2:0]        tsz_i,
  output logic [PA_W-1:0]   ent_addr_o,
  output logic              tsz_err_o
);
  localparam int OFF_W = DMA_AW + 3;

  logic [NUM_TSZ-1:0][DMA_AW-1:0] idx_mask;
  logic [DMA_AW-1:0] shifted;
  logic [DMA_AW-1:0] idx;
  logic [OFF_W-1:0]  off;
  logic unused_base;

  // Index width grows by one bit per table-size step
  for (genvar c = 0; c < NUM_TSZ; c++) begin : g_mask
    assign idx_mask[c] = DMA_AW'((64'd1 << (IDX_MIN_BITS + c)) - 64'd1);
  end

  assign shifted    = pg64_i ? (dma_addr_i >> LARGE_SHIFT) : (dma_addr_i >> SMALL_SHIFT);
  assign idx        = shifted & idx_mask[tsz_i];
  assign off        = {idx, 3'b000};
  assign ent_addr_o = base_i[PA_W-1:0] + PA_W'(off);
  assign tsz_err_o  = pg64_i && (tsz_i > 3'(MAX_LARGE_TSZ));
  assign unused_base = ^base_i[63:PA_W];
endmodule

// File: rtl/dxl_walk.sv
`timescale 1ns/1ps
module dxl_walk
  import dxl_pkg::*;
#(
  parameter int DMA_AW = 32,
  parameter int PA_W   = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DMA_AW-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              en_i,
  input  logic              tsz_err_i,
  input  logic [PA_W-1:0]   ent_addr_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        fault_o
);
  localparam logic [PA_W-1:0] ALL_ONES   = '1;
  localparam logic [PA_W-1:0] SMALL_MASK = ALL_ONES << SMALL_SHIFT;
  localparam logic [PA_W-1:0] LARGE_MASK = ALL_ONES << LARGE_PHYS_LSB;
  localparam int NBYTES = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e                 st_q;
  logic [LARGE_SHIFT-1:0] a_q;
  logic                wr_q;
  logic [PA_W-1:0]     maddr_q;
  logic                done_q;
  logic [PA_W-1:0]     pa_q;
  dxl_fault_e          fault_q;
  logic [63:0]         ent;
  logic [PA_W-1:0]     pa_hit;
  logic                unused_ent;

  // Big-endian entry: lowest-address byte is most significant
  for (genvar k = 0; k < NBYTES; k++) begin : g_swap
    assign ent[8*(NBYTES-1-k) +: 8] = mem_rdata_i[8*k +: 8];
  end

  assign pa_hit = ent[ENT_BIG_BIT]
                ? ((ent[PA_W-1:0] & LARGE_MASK) | PA_W'(a_q))
                : ((ent[PA_W-1:0] & SMALL_MASK) | PA_W'(a_q[SMALL_SHIFT-1:0]));
  assign unused_ent = ^{ent[62], ent[60:PA_W], ent[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      a_q     <= '0;
      wr_q    <= 1'b0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          a_q  <= req_addr_i[LARGE_SHIFT-1:0];
          wr_q <= req_write_i;
          if (!en_i) begin
            done_q  <= 1'b1;
            pa_q    <= PA_W'(req_addr_i);
            fault_q <= FLT_NONE;
          end else if (tsz_err_i) begin
            done_q  <= 1'b1;
            pa_q    <= '0;
            fault_q <= FLT_TSIZE;
          end else begin
            maddr_q <= ent_addr_i;
            st_q    <= ST_REQ;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: if (mem_valid_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          if (!ent[ENT_VALID_BIT]) begin
            pa_q    <= '0;
            fault_q <= FLT_INVALID;
          end else if (wr_q && !ent[ENT_WR_BIT]) begin
            pa_q    <= '0;
            fault_q <= FLT_WPROT;
          end else begin
            pa_q    <= pa_hit;
            fault_q <= FLT_NONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_REQ);
  assign mem_addr_o  = maddr_q;
  assign done_o      = done_q;
  assign pa_o        = pa_q;
  assign fault_o     = fault_q;

  // R10
  mem_req_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R10
  done_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && mem_valid_i) |=> done_o);
  // R9
  pa_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_NONE) |-> pa_o[SMALL_SHIFT-1:0] == a_q[SMALL_SHIFT-1:0]);
  // R8
  wprot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_WPROT) |-> wr_q);
endmodule

// File: rtl/dma_xlate.sv
`timescale 1ns/1ps
module dma_xlate
  import dxl_pkg::*;
#(
  parameter int DMA_AW = 32,
  parameter int PA_W   = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DMA_AW-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        fault_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [63:0]       mem_rdata_i
);
  logic [63:0]     ctrl;
  logic [63:0]     base;
  logic [PA_W-1:0] ent_addr;
  logic            tsz_err;
  logic            unused_ctrl;

  assign unused_ctrl = ^{ctrl[63:CTRL_TSZ_LSB+3], ctrl[CTRL_TSZ_LSB-1:CTRL_PG64_BIT+1], ctrl[1]};

  dxl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .base_o  (base)
  );

  dxl_index #(.DMA_AW(DMA_AW), .PA_W(PA_W)) u_index (
    .dma_addr_i (req_addr_i),
    .base_i     (base),
    .pg64_i     (ctrl[CTRL_PG64_BIT]),
    .tsz_i      (ctrl[CTRL_TSZ_LSB +: 3]),
    .ent_addr_o (ent_addr),
    .tsz_err_o  (tsz_err)
  );

  dxl_walk #(.DMA_AW(DMA_AW), .PA_W(PA_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .en_i        (ctrl[CTRL_EN_BIT]),
    .tsz_err_i   (tsz_err),
    .ent_addr_i  (ent_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .pa_o        (pa_o),
    .fault_o     (fault_o)
  );

  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !ctrl[CTRL_EN_BIT])
      |=> (done_o && fault_o == 2'd0 && pa_o == PA_W'($past(req_addr_i))));
endmodule

// File: tb/dma_xlate_tb.sv
`timescale 1ns/1ps
module dma_xlate_tb;
  localparam int AW = 32;
  localparam int PW = 41;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic done;
  logic [PW-1:0] pa, mem_addr;
  logic [1:0] fault;
  logic mem_req, mem_valid = 0;
  logic [63:0] mem_rdata = 0;

  int n_chk = 0, n_fail = 0;
  int fetch_n = 0, pend = 0;
  logic [PW-1:0] fetch_addr = 0;
  logic [63:0] ent_val = 0;
  logic [63:0] base_val = 64'h0000_00AB_CD00_0000;

  always #5 clk = ~clk;

  dma_xlate #(.DMA_AW(AW), .PA_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_write_i(req_write),
    .done_o(done), .pa_o(pa), .fault_o(fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [63:0] be_bytes(logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  // Memory model: answers each read pulse after two cycles
  always @(negedge clk) begin
    mem_valid = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_valid = 1;
        mem_rdata = be_bytes(ent_val);
      end
    end
    if (mem_req) begin
      fetch_n++;
      fetch_addr = mem_addr;
      pend = 2;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic set_ctrl(input bit en, input bit pg, input int c);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[2] = pg; v[18:16] = 3'(c);
    wr_reg(4'h4, v);
  endtask

  function automatic logic [PW-1:0] exp_ent(input bit pg, input int c, input logic [AW-1:0] a);
    logic [63:0] idx;
    idx = pg ? (64'(a) >> 16) : (64'(a) >> 13);
    idx &= (64'd1 << (10 + c)) - 64'd1;
    return base_val[PW-1:0] + PW'(idx << 3);
  endfunction

  function automatic logic [PW-1:0] exp_pa(input logic [63:0] e, input logic [AW-1:0] a);
    if (e[61]) return (e[PW-1:0] & 41'h1FF_FFFF_8000) | PW'(a[15:0]);
    return (e[PW-1:0] & 41'h1FF_FFFF_E000) | PW'(a[12:0]);
  endfunction

  task automatic run(input string rq, input bit en, input bit pg, input int c,
                     input logic [AW-1:0] a, input bit wr, input logic [63:0] e);
    bit fetch_exp, seen;
    logic [1:0] f_exp;
    logic [PW-1:0] pa_exp;
    int f0;
    set_ctrl(en, pg, c);
    ent_val = e;
    fetch_exp = en && !(pg && c > 5);
    if (!en) begin f_exp = 0; pa_exp = PW'(a); end
    else if (!fetch_exp) begin f_exp = 3; pa_exp = 0; end
    else if (!e[63]) begin f_exp = 1; pa_exp = 0; end
    else if (wr && !e[1]) begin f_exp = 2; pa_exp = 0; end
    else begin f_exp = 0; pa_exp = exp_pa(e, a); end
    f0 = fetch_n;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    // R10: busy while the entry read is outstanding
    if (fetch_exp) chk(req_ready == 0, {rq, " R10 ready low"}, 64'(req_ready), 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {rq, " done"}, 64'(seen), 1);
    chk(pa == pa_exp, {rq, " pa"}, 64'(pa), 64'(pa_exp));
    chk(fault == f_exp, {rq, " fault"}, 64'(fault), 64'(f_exp));
    chk((fetch_n - f0) == (fetch_exp ? 1 : 0), {rq, " R10 read count"}, 64'(fetch_n - f0), 64'(fetch_exp));
    if (fetch_exp)
      chk(fetch_addr == exp_ent(pg, c, a), {rq, " entry addr"}, 64'(fetch_addr), 64'(exp_ent(pg, c, a)));
    @(negedge clk);
    chk(done == 0, {rq, " R10 done pulse"}, 64'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h5555_5555;
    pats[2] = 32'hAAAA_AAAA; pats[3] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int h = 0; h < 4; h++) begin
      reg_addr = 4'(h * 4); #1;
      chk(reg_rdata == 0, "R1 reset half", 64'(reg_rdata), 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && mem_req == 0 && req_ready == 1, "R10 idle after reset", 64'({done, mem_req, req_ready}), 64'b001);
    // R1: halves
    wr_reg(4'h0, 32'hDEAD_BEEF);
    wr_reg(4'h4, 32'h0000_0000);
    wr_reg(4'h8, base_val[63:32]);
    wr_reg(4'hC, base_val[31:0]);
    reg_addr = 4'h0; #1; chk(reg_rdata == 32'hDEAD_BEEF, "R1 ctrl hi", 64'(reg_rdata), 64'hDEAD_BEEF);
    reg_addr = 4'h4; #1; chk(reg_rdata == 0, "R1 ctrl lo", 64'(reg_rdata), 0);
    reg_addr = 4'h8; #1; chk(reg_rdata == base_val[63:32], "R1 base hi", 64'(reg_rdata), 64'(base_val[63:32]));
    reg_addr = 4'hE; #1; chk(reg_rdata == base_val[31:0], "R1 base lo", 64'(reg_rdata), 64'(base_val[31:0]));
    wr_reg(4'h0, 32'h0);
    // R2: passthrough
    foreach (pats[p]) run("R2 bypass", 0, 0, 0, pats[p], p[0], 64'h0);
    // R3 / R4 / R5 sweep over table sizes and page sizes
    for (int pg = 0; pg < 2; pg++)
      for (int c = 0; c < 8; c++)
        foreach (pats[p])
          run(pg ? ((c > 5) ? "R5 large bad size" : "R4 large table") : "R3 small table",
              1, pg[0], c, pats[p], 0, 64'h8000_0123_4567_8002);
    // R6 / R9: byte order and both page sizes
    run("R6 R9 small page", 1, 0, 3, 32'h0123_4567, 0, 64'h8000_01AB_CDEF_1357);
    run("R6 R9 large page", 1, 1, 2, 32'h0765_FEDC, 0, 64'hA000_00FE_DCBA_9876);
    // R7: invalid entries
    run("R7 invalid read", 1, 0, 0, 32'h0000_4000, 0, 64'h2000_0123_4567_8002);
    run("R7 invalid write", 1, 1, 1, 32'h0004_0000, 1, 64'h0000_0000_0000_0000);
    // R8: write permission
    run("R8 write ro", 1, 0, 2, 32'h0010_2000, 1, 64'h8000_0100_0000_0000);
    run("R8 read ro", 1, 0, 2, 32'h0010_2000, 0, 64'h8000_0100_0000_0000);
    run("R8 write rw", 1, 1, 0, 32'h0010_2000, 1, 64'hA000_0100_0000_0002);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule